// File: doc/BRIEF.md
# Replicated Write Transmit Queue

This block sits between a host's writes into replicated shared memory and the ring transmitter. Every accepted host write becomes one queue entry: a 21-bit longword address, a 32-bit data word and a single interrupt tag. The transmitter drains entries in arrival order through a valid/pop interface. The block does not serialize onto the ring or update local memory.

The interrupt tag is fixed when the write is accepted. It is set in either of two cases: the global override control is set, or both the per-word transmit-interrupt enable and the global network-interrupt enable are set.

A full queue is handled in one of two ways, chosen by the holdoff control:
- With holdoff enabled, the host write port drops its ready signal until an entry leaves, so the write waits.
- With holdoff disabled, a write arriving at a full queue with no pop in that cycle is discarded, and a sticky overflow flag is raised.

Top module: `repl_write_queue`

## Requirements
- R1: After reset the queue is empty: txValid=0, fullFlag=0, overflowFlag=0, hostReady=1.
- R2: Entries leave in the order they were accepted. Address and data are unchanged, and a head entry that is not popped stays stable on the outputs.
- R3: The interrupt tag of an entry equals irqOverride OR (wordIrqEn AND netIrqEn), sampled in the cycle the write is accepted.
- R4: fullFlag is 1 exactly when DEPTH entries are held. A full queue always shows txValid=1.
- R5: With holdoffEn=1 and a full queue, hostReady is 0 and no write is taken. A pending write is accepted in the cycle after a pop frees a slot.
- R6: With holdoffEn=0 and a full queue, a write with no pop in the same cycle is discarded. The discard sets overflowFlag.
- R7: overflowFlag stays set until an ovfClr pulse. If a discard and ovfClr occur in the same cycle, the flag ends set.
- R8: With holdoffEn=0, a write and a pop in the same cycle on a full queue are both performed. The queue stays full and no overflow is raised.
- R9: txValid is 1 exactly when at least one entry is held. A pop on an empty queue has no effect.
- R10: hostReady is 1 whenever holdoff is disabled or the queue is not full.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| hostValid | input | 1 | Host write request |
| hostAddr | input | ADDR_W | Longword address of the write |
| hostData | input | DATA_W | Write data |
| hostReady | output | 1 | Write accepted or discarded when high with hostValid |
| wordIrqEn | input | 1 | Per-word transmit-interrupt enable for this address |
| netIrqEn | input | 1 | Global network-interrupt enable |
| irqOverride | input | 1 | Tag every write with an interrupt |
| holdoffEn | input | 1 | Stall writes instead of discarding them when full |
| ovfClr | input | 1 | Clear the sticky overflow flag |
| fullFlag | output | 1 | Queue holds DEPTH entries |
| overflowFlag | output | 1 | Sticky: a write was discarded |
| txValid | output | 1 | Head entry present |
| txAddr | output | ADDR_W | Head entry address |
| txData | output | DATA_W | Head entry data |
| txIrq | output | 1 | Head entry interrupt tag |
| txPop | input | 1 | Remove the head entry |

## Verification
The hardest states to reach from the ports are the ones where a full queue meets a write in the same cycle as a pop, or meets an overflow clear. These occur only at exact occupancy, and only for one holdoff setting each.

The bench uses a four-entry configuration so the queue can be filled in a few writes. From the full state it applies each combination deliberately: a stalled write held across several cycles and then released by a pop, a discarded write, a simultaneous write and pop, and a discard coinciding with a clear.

A reference queue in the bench then verifies that the drained order and contents are unaffected. All eight combinations of the three interrupt controls are also swept.

// File: rtl/rwq_pkg.sv
package rwq_pkg;
  typedef struct packed {
    logic push;
    logic pop;
  } qStrobe_t;
endpackage

// File: rtl/rwq_ctrl.sv
module rwq_ctrl
  import rwq_pkg::*;
#(
  parameter int DEPTH = 1024
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     hostValid,
  input  logic     holdoffEn,
  input  logic     ovfClr,
  input  logic     txPop,
  output logic     hostReady,
  output logic     fullFlag,
  output logic     overflowFlag,
  output logic     txValid,
  output qStrobe_t strobe
);
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

  logic [CNT_W-1:0] count;
  logic isFull, isEmpty, popNow, pushNow, dropNow;

  assign isFull  = (count == FULL_CNT);
  assign isEmpty = (count == '0);
  assign popNow  = txPop && !isEmpty;
  assign hostReady = !(holdoffEn && isFull);
  // a full queue accepts only if a slot frees in the same cycle
  assign pushNow = hostValid && hostReady && (!isFull || popNow);
  assign dropNow = hostValid && hostReady && isFull && !popNow;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      count <= '0;
    end else begin
      case ({pushNow, popNow})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)        overflowFlag <= 1'b0;
    else if (dropNow) overflowFlag <= 1'b1;
    else if (ovfClr)  overflowFlag <= 1'b0;
  end

  assign strobe.push = pushNow;
  assign strobe.pop  = popNow;
  assign fullFlag    = isFull;
  assign txValid     = !isEmpty;
endmodule

// File: rtl/rwq_store.sv
module rwq_store
  import rwq_pkg::*;
#(
  parameter int ADDR_W = 21,
  parameter int DATA_W = 32,
  parameter int DEPTH  = 1024
) (
  input  logic              clk,
  input  logic              rstN,
  input  qStrobe_t          strobe,
  input  logic [ADDR_W-1:0] inAddr,
  input  logic [DATA_W-1:0] inData,
  input  logic              wordIrqEn,
  input  logic              netIrqEn,
  input  logic              irqOverride,
  output logic [ADDR_W-1:0] outAddr,
  output logic [DATA_W-1:0] outData,
  output logic              outIrq
);
  localparam int ENTRY_W = ADDR_W + DATA_W + 1;
  localparam int PTR_W   = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(DEPTH - 1);

  logic [ENTRY_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]   wrPtr, rdPtr;
  logic               tagBit;
  logic [ENTRY_W-1:0] headEntry;

  function automatic logic [PTR_W-1:0] nextPtr(input logic [PTR_W-1:0] p);
    return (p == LAST_PTR) ? '0 : p + 1'b1;
  endfunction

  assign tagBit = irqOverride | (wordIrqEn & netIrqEn);

  always_ff @(posedge clk) begin
    if (strobe.push) mem[wrPtr] <= {tagBit, inAddr, inData};
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
    end else begin
      if (strobe.push) wrPtr <= nextPtr(wrPtr);
      if (strobe.pop)  rdPtr <= nextPtr(rdPtr);
    end
  end

  assign headEntry = mem[rdPtr];
  assign outIrq    = headEntry[ENTRY_W-1];
  assign outAddr   = headEntry[DATA_W +: ADDR_W];
  assign outData   = headEntry[DATA_W-1:0];
endmodule

// File: rtl/repl_write_queue.sv
module repl_write_queue
  import rwq_pkg::*;
#(
  parameter int ADDR_W = 21,
  parameter int DATA_W = 32,
  parameter int DEPTH  = 1024
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              hostValid,
  input  logic [ADDR_W-1:0] hostAddr,
  input  logic [DATA_W-1:0] hostData,
  output logic              hostReady,
  input  logic              wordIrqEn,
  input  logic              netIrqEn,
  input  logic              irqOverride,
  input  logic              holdoffEn,
  input  logic              ovfClr,
  output logic              fullFlag,
  output logic              overflowFlag,
  output logic              txValid,
  output logic [ADDR_W-1:0] txAddr,
  output logic [DATA_W-1:0] txData,
  output logic              txIrq,
  input  logic              txPop
);
  qStrobe_t strobe;

  rwq_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk(clk), .rstN(rstN), .hostValid(hostValid), .holdoffEn(holdoffEn),
    .ovfClr(ovfClr), .txPop(txPop), .hostReady(hostReady),
    .fullFlag(fullFlag), .overflowFlag(overflowFlag), .txValid(txValid),
    .strobe(strobe)
  );

  rwq_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .DEPTH(DEPTH)) u_store (
    .clk(clk), .rstN(rstN), .strobe(strobe), .inAddr(hostAddr),
    .inData(hostData), .wordIrqEn(wordIrqEn), .netIrqEn(netIrqEn),
    .irqOverride(irqOverride), .outAddr(txAddr), .outData(txData),
    .outIrq(txIrq)
  );
endmodule

// File: rtl/repl_write_queue_chk.sv
module repl_write_queue_chk #(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              hostValid,
  input logic              hostReady,
  input logic              holdoffEn,
  input logic              ovfClr,
  input logic              fullFlag,
  input logic              overflowFlag,
  input logic              txValid,
  input logic [DATA_W-1:0] txData,
  input logic              txPop
);
  // R4
  full_has_head_chk: assert property (@(posedge clk) disable iff (!rstN)
    fullFlag |-> txValid);

  // R5
  holdoff_stall_chk: assert property (@(posedge clk) disable iff (!rstN)
    (holdoffEn && fullFlag && !txPop) |=> fullFlag);

  // R6
  drop_sets_ovf_chk: assert property (@(posedge clk) disable iff (!rstN)
    (hostValid && hostReady && fullFlag && !txPop) |=> overflowFlag);

  // R7
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    (overflowFlag && !ovfClr) |=> overflowFlag);

  // R8
  full_pushpop_chk: assert property (@(posedge clk) disable iff (!rstN)
    (fullFlag && hostValid && hostReady && txPop) |=> fullFlag);

  // R9
  empty_pop_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!txValid && !hostValid) |=> !txValid);

  // R2
  head_stable_chk: assert property (@(posedge clk) disable iff (!rstN)
    (txValid && !txPop) |=> (txValid && $stable(txData)));
endmodule

bind repl_write_queue repl_write_queue_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rstN(rstN), .hostValid(hostValid), .hostReady(hostReady),
  .holdoffEn(holdoffEn), .ovfClr(ovfClr), .fullFlag(fullFlag),
  .overflowFlag(overflowFlag), .txValid(txValid), .txData(txData),
  .txPop(txPop)
);

// File: tb/repl_write_queue_bench.sv
module repl_write_queue_bench;
  localparam int AW = 21;
  localparam int DW = 32;
  localparam int DEPTH = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic hostValid = 1'b0, wordIrqEn = 1'b0, netIrqEn = 1'b0, irqOverride = 1'b0;
  logic holdoffEn = 1'b0, ovfClr = 1'b0, txPop = 1'b0;
  logic [AW-1:0] hostAddr = '0;
  logic [DW-1:0] hostData = '0;
  logic hostReady, fullFlag, overflowFlag, txValid, txIrq;
  logic [AW-1:0] txAddr;
  logic [DW-1:0] txData;

  int errors = 0;
  int checks = 0;
  logic [AW+DW:0] model[$];

  always #10 clk = ~clk;

  repl_write_queue #(.ADDR_W(AW), .DATA_W(DW), .DEPTH(DEPTH)) u_repl_write_queue (
    .clk(clk), .rstN(rstN), .hostValid(hostValid), .hostAddr(hostAddr),
    .hostData(hostData), .hostReady(hostReady), .wordIrqEn(wordIrqEn),
    .netIrqEn(netIrqEn), .irqOverride(irqOverride), .holdoffEn(holdoffEn),
    .ovfClr(ovfClr), .fullFlag(fullFlag), .overflowFlag(overflowFlag),
    .txValid(txValid), .txAddr(txAddr), .txData(txData), .txIrq(txIrq),
    .txPop(txPop)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  // drive one write for one cycle; expAccept says whether the model stores it
  task automatic writeWord(input logic [AW-1:0] a, input logic [DW-1:0] d,
                           input bit we, input bit ne, input bit ov,
                           input bit expAccept);
    @(negedge clk);
    hostAddr = a; hostData = d; wordIrqEn = we; netIrqEn = ne; irqOverride = ov;
    hostValid = 1'b1;
    @(negedge clk);
    hostValid = 1'b0;
    if (expAccept) model.push_back({ov | (we & ne), a, d});
  endtask

  // compare head with the model (R2, R3)
  task automatic checkHead();
    logic [AW+DW:0] e;
    e = model[0];
    chk(txValid == 1'b1, "R9 head present", 64'(txValid), 64'd1);
    chk(txAddr == e[DW +: AW], "R2 address order", 64'(txAddr), 64'(e[DW +: AW]));
    chk(txData == e[DW-1:0], "R2 data order", 64'(txData), 64'(e[DW-1:0]));
    chk(txIrq == e[AW+DW], "R3 interrupt tag", 64'(txIrq), 64'(e[AW+DW]));
  endtask

  task automatic popWord();
    @(negedge clk); #1;
    checkHead();
    txPop = 1'b1;
    @(negedge clk);
    txPop = 1'b0;
    void'(model.pop_front());
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    chk(1'b0, "watchdog expired", 64'd0, 64'd1);
    finishRun();
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    #1;
    // R1
    chk(txValid == 0, "R1 reset txValid", 64'(txValid), 64'd0);
    chk(fullFlag == 0, "R1 reset fullFlag", 64'(fullFlag), 64'd0);
    chk(overflowFlag == 0, "R1 reset overflow", 64'(overflowFlag), 64'd0);
    chk(hostReady == 1, "R1 reset hostReady", 64'(hostReady), 64'd1);

    // R9: pop on empty queue
    @(negedge clk); txPop = 1'b1;
    @(negedge clk); txPop = 1'b0; #1;
    chk(txValid == 0, "R9 pop on empty", 64'(txValid), 64'd0);
    chk(fullFlag == 0, "R9 pop on empty full", 64'(fullFlag), 64'd0);

    // R3: sweep all tag controls
    for (int k = 0; k < 8; k++) begin
      writeWord(AW'(k * 21'h1111 + 5), DW'(k) * 32'h0101_0101 ^ 32'hA5A5_0000,
                k[0], k[1], k[2], 1'b1);
      popWord();
    end

    // R4: fill to capacity
    for (int k = 0; k < DEPTH; k++) begin
      writeWord(AW'(21'h1F0000 + k), 32'hC000_0000 + DW'(k), k[0], 1'b1, 1'b0, 1'b1);
      #1;
      chk(fullFlag == (k == DEPTH - 1), "R4 full at capacity",
          64'(fullFlag), 64'(k == DEPTH - 1));
    end

    // R6: discard when full without holdoff
    holdoffEn = 1'b0;
    writeWord(21'h0ABCDE, 32'hDEAD_BEEF, 1'b1, 1'b1, 1'b1, 1'b0);
    #1;
    chk(overflowFlag == 1, "R6 overflow on discard", 64'(overflowFlag), 64'd1);
    chk(fullFlag == 1, "R6 still full", 64'(fullFlag), 64'd1);

    // R7: clear overflow
    @(negedge clk); ovfClr = 1'b1;
    @(negedge clk); ovfClr = 1'b0; #1;
    chk(overflowFlag == 0, "R7 overflow cleared", 64'(overflowFlag), 64'd0);

    // R5: holdoff stall, then release by a pop
    @(negedge clk);
    holdoffEn = 1'b1;
    hostAddr = 21'h012345; hostData = 32'h5555_AAAA;
    wordIrqEn = 1'b0; netIrqEn = 1'b0; irqOverride = 1'b1;
    hostValid = 1'b1;
    for (int c = 0; c < 3; c++) begin
      #1;
      chk(hostReady == 0, "R5 ready low while full", 64'(hostReady), 64'd0);
      @(negedge clk);
    end
    #1;
    chk(fullFlag == 1, "R5 no entry taken", 64'(fullFlag), 64'd1);
    checkHead();
    txPop = 1'b1;
    @(negedge clk);
    txPop = 1'b0;
    void'(model.pop_front());
    #1;
    chk(hostReady == 1, "R5 ready after pop", 64'(hostReady), 64'd1);
    @(negedge clk);
    hostValid = 1'b0;
    model.push_back({1'b1, 21'h012345, 32'h5555_AAAA});
    #1;
    chk(fullFlag == 1, "R5 write taken after slot freed", 64'(fullFlag), 64'd1);
    chk(hostReady == 0, "R5 ready low again", 64'(hostReady), 64'd0);
    chk(overflowFlag == 0, "R5 no overflow with holdoff", 64'(overflowFlag), 64'd0);

    // R8: push and pop together while full
    @(negedge clk);
    holdoffEn = 1'b0; #1;
    chk(hostReady == 1, "R10 ready when holdoff off", 64'(hostReady), 64'd1);
    checkHead();
    hostAddr = 21'h1ABCDE; hostData = 32'h1234_5678;
    wordIrqEn = 1'b1; netIrqEn = 1'b1; irqOverride = 1'b0;
    hostValid = 1'b1; txPop = 1'b1;
    @(negedge clk);
    hostValid = 1'b0; txPop = 1'b0;
    void'(model.pop_front());
    model.push_back({1'b1, 21'h1ABCDE, 32'h1234_5678});
    #1;
    chk(fullFlag == 1, "R8 stays full", 64'(fullFlag), 64'd1);
    chk(overflowFlag == 0, "R8 no overflow", 64'(overflowFlag), 64'd0);

    // R7: discard and clear in the same cycle
    @(negedge clk);
    hostAddr = 21'h000001; hostData = 32'hFFFF_0000;
    hostValid = 1'b1; ovfClr = 1'b1;
    @(negedge clk);
    hostValid = 1'b0; ovfClr = 1'b0; #1;
    chk(overflowFlag == 1, "R7 set wins over clear", 64'(overflowFlag), 64'd1);

    // drain (R2) and check empty state
    for (int k = 0; k < DEPTH; k++) popWord();
    #1;
    chk(txValid == 0, "R9 empty after drain", 64'(txValid), 64'd0);
    chk(fullFlag == 0, "R4 not full after drain", 64'(fullFlag), 64'd0);
    holdoffEn = 1'b1; #1;
    chk(hostReady == 1, "R10 ready when not full", 64'(hostReady), 64'd1);
    chk(overflowFlag == 1, "R7 sticky until cleared", 64'(overflowFlag), 64'd1);

    finishRun();
  end
endmodule